// File: doc/BRIEF.md
# Four-Channel Power-Good Generator

This block drives one power-good level for each of four regulator channels. Each channel has two comparator flags that arrive without a clock: one says the rail has reached its upper threshold, the other says it has fallen under its lower threshold. The two thresholds sit a few percent apart, which gives the output hysteresis. The block also takes each channel's enable, a per-channel running indication from the sequencing controller, and one global fault warning. That warning is raised on overvoltage or over-temperature, ahead of a delayed rail shutdown, so downstream logic gets notice before the supplies go away.

A channel's output falls when its rail drops out of regulation, when it is disabled or not running, or when the fault warning is present. Every fall starts a minimum low interval that lasts `HOLD_CYCLES` clocks. The default is 50 ms at 125 MHz. The output returns high only when three things are true: that interval has expired, the channel is enabled and running with no fault, and the rail is back above the upper threshold. So a short fault still yields a full-length low pulse. After a long fault, the output is released as soon as the rail is good again.

Top module: `pg_good_gen`

## Requirements
- R1: While reset is asserted, all four outputs are low. The hold interval applies from reset release. With all channels ready, every output is still low after edge `HOLD_CYCLES` and goes high on edge `HOLD_CYCLES`+1 after reset release.
- R2: An output rises only when its interval has expired, its enable and running inputs are high, the fault warning is low, and its synchronised upper-threshold flag is set.
- R3: Both comparator flags pass through two synchronising flops before they are used. A change on a flag reaches the output on the third rising clock edge after it is applied.
- R4: While both of a channel's flags are clear (rail between the thresholds), the output keeps its current value, whether high or low.
- R5: Each fall holds the output low for at least `HOLD_CYCLES` edges. If the channel is already ready, the output rises on edge `HOLD_CYCLES`+1 after the edge that dropped it.
- R6: A low enable drives that channel's output low on the next clock edge. Other channels are not affected.
- R7: A low running input drives that channel's output low on the next clock edge.
- R8: The fault warning drives all four outputs low on the next edge. A fault shorter than the hold interval still gives release only at the end of the interval. After a fault longer than the interval, the outputs rise on the first edge that sees the fault cleared.
- R9: The hold interval restarts on every high-to-low transition of the output. A further drop cause while the output is already low does not restart it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanEn | input | 4 | Per-channel enable |
| chanRun | input | 4 | Per-channel running indication from the sequencer |
| aboveHi | input | 4 | Asynchronous flag: rail at or above the upper threshold |
| belowLo | input | 4 | Asynchronous flag: rail below the lower threshold |
| faultWarn | input | 1 | Global fault warning (overvoltage or over-temperature) |
| pgood | output | 4 | Per-channel power-good level |

## Verification
Hold expiry and a new drop cause can land in the same clock edge. When they do, the block must decide whether the channel that was about to release is dropped again and whether its interval restarts. The bench provokes this by disabling channel 0 at a known edge, then raising the fault warning so that it is first seen on exactly the edge where channel 0's interval has run out. The expected result is that all outputs are low on that edge. After the fault clears, channel 0 alone rises one edge later, with no new interval, while the three channels that dropped on that edge wait a full interval of their own.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int unsigned PG_CH = 4;

  typedef struct packed {
    logic [PG_CH-1:0] holdLoad;
  } pgStrobe_t;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/pg_hold_timer.sv
module pg_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 6250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic expired
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               remain <= LOAD_VAL;
    else if (load)           remain <= LOAD_VAL;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/pg_datapath.sv
module pg_datapath
  import pg_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 6250000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PG_CH-1:0] aboveHi,
  input  logic [PG_CH-1:0] belowLo,
  input  pgStrobe_t        strobe,
  output logic [PG_CH-1:0] aboveSync,
  output logic [PG_CH-1:0] belowSync,
  output logic [PG_CH-1:0] holdDone
);
  logic [2*PG_CH-1:0] flagSync;

  pg_sync #(.WIDTH(2*PG_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({belowLo, aboveHi}),
    .syncOut (flagSync)
  );

  assign aboveSync = flagSync[PG_CH-1:0];
  assign belowSync = flagSync[2*PG_CH-1:PG_CH];

  for (genvar c = 0; c < PG_CH; c++) begin : g_hold
    pg_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk     (clk),
      .rstN    (rstN),
      .load    (strobe.holdLoad[c]),
      .expired (holdDone[c])
    );
  end
endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import pg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PG_CH-1:0] chanEn,
  input  logic [PG_CH-1:0] chanRun,
  input  logic             faultWarn,
  input  logic [PG_CH-1:0] aboveSync,
  input  logic [PG_CH-1:0] belowSync,
  input  logic [PG_CH-1:0] holdDone,
  output pgStrobe_t        strobe,
  output logic [PG_CH-1:0] pgood
);
  logic [PG_CH-1:0] pgoodQ;
  logic [PG_CH-1:0] pgoodD;
  logic [PG_CH-1:0] dropCause;
  logic [PG_CH-1:0] releaseOk;
  logic [PG_CH-1:0] faultVec;

  always_comb begin
    faultVec  = {PG_CH{faultWarn}};
    dropCause = ~chanEn | ~chanRun | belowSync | faultVec;
    releaseOk = holdDone & chanEn & chanRun & aboveSync & ~belowSync & ~faultVec;
    pgoodD    = (pgoodQ & ~dropCause) | (~pgoodQ & releaseOk);
    strobe.holdLoad = pgoodQ & dropCause;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pgoodQ <= '0;
    else       pgoodQ <= pgoodD;
  end

  assign pgood = pgoodQ;
endmodule

// File: rtl/pg_good_gen.sv
module pg_good_gen
  import pg_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 6250000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PG_CH-1:0] chanEn,
  input  logic [PG_CH-1:0] chanRun,
  input  logic [PG_CH-1:0] aboveHi,
  input  logic [PG_CH-1:0] belowLo,
  input  logic             faultWarn,
  output logic [PG_CH-1:0] pgood
);
  pgStrobe_t        strobe;
  logic [PG_CH-1:0] aboveSync;
  logic [PG_CH-1:0] belowSync;
  logic [PG_CH-1:0] holdDone;

  pg_datapath #(.HOLD_CYCLES(HOLD_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .aboveHi   (aboveHi),
    .belowLo   (belowLo),
    .strobe    (strobe),
    .aboveSync (aboveSync),
    .belowSync (belowSync),
    .holdDone  (holdDone)
  );

  pg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chanEn    (chanEn),
    .chanRun   (chanRun),
    .faultWarn (faultWarn),
    .aboveSync (aboveSync),
    .belowSync (belowSync),
    .holdDone  (holdDone),
    .strobe    (strobe),
    .pgood     (pgood)
  );
endmodule

// File: rtl/pg_good_gen_chk.sv
module pg_good_gen_chk
  import pg_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 6250000
) (
  input logic             clk,
  input logic             rstN,
  input logic [PG_CH-1:0] chanEn,
  input logic [PG_CH-1:0] chanRun,
  input logic             faultWarn,
  input logic [PG_CH-1:0] pgood
);
  localparam int unsigned LW = $clog2(HOLD_CYCLES + 2);
  localparam logic [LW-1:0] LOW_MAX = LW'(HOLD_CYCLES + 1);
  localparam logic [LW-1:0] LOW_MIN = LW'(HOLD_CYCLES);

  logic [LW-1:0] lowRun [PG_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < PG_CH; c++) lowRun[c] <= '0;
    end else begin
      for (int c = 0; c < PG_CH; c++) begin
        if (pgood[c])                 lowRun[c] <= '0;
        else if (lowRun[c] != LOW_MAX) lowRun[c] <= lowRun[c] + 1'b1;
      end
    end
  end

  AST_FAULT_ALL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    faultWarn |=> (pgood == '0)); // R8

  for (genvar c = 0; c < PG_CH; c++) begin : g_chk
    AST_ENABLE_DROP: assert property (@(posedge clk) disable iff (!rstN)
      !chanEn[c] |=> !pgood[c]); // R6
    AST_RUN_DROP: assert property (@(posedge clk) disable iff (!rstN)
      !chanRun[c] |=> !pgood[c]); // R7
    AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pgood[c]) |-> $past(chanEn[c] && chanRun[c] && !faultWarn)); // R2
    AST_MIN_LOW_TIME: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pgood[c]) |-> (lowRun[c] >= LOW_MIN)); // R5
  end
endmodule

bind pg_good_gen pg_good_gen_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chanEn    (chanEn),
  .chanRun   (chanRun),
  .faultWarn (faultWarn),
  .pgood     (pgood)
);

// File: tb/tb_pg_good_gen.sv
module tb_pg_good_gen;
  localparam int unsigned HOLD = 40;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] chanEn, chanRun, aboveHi, belowLo;
  logic       faultWarn;
  logic [3:0] pgood;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  always #4 clk = ~clk;

  pg_good_gen #(.HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .chanRun(chanRun),
    .aboveHi(aboveHi), .belowLo(belowLo), .faultWarn(faultWarn), .pgood(pgood)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] mask, input logic [3:0] exp);
    nChecks++;
    if ((pgood & mask) !== (exp & mask)) begin
      nFails++;
      $display("FAIL %s: pgood=%b expected=%b (mask %b)", req, pgood, exp, mask);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  task automatic testReset();
    rstN = 1'b0; chanEn = 4'hF; chanRun = 4'hF; aboveHi = 4'hF; belowLo = 4'h0; faultWarn = 1'b0;
    tick(3);
    check("R1 low in reset", 4'hF, 4'h0);
    rstN = 1'b1;
    tick(HOLD);
    check("R1 hold from reset", 4'hF, 4'h0);
    tick(1);
    check("R1 release after reset hold", 4'hF, 4'hF);
  endtask

  task automatic testBelowDrop();
    belowLo[1] = 1'b1; aboveHi[1] = 1'b0;
    tick(2);
    check("R3 not yet through sync", 4'hF, 4'hF);
    tick(1);
    check("R3 drop on third edge", 4'hF, 4'b1101);
    belowLo[1] = 1'b0; aboveHi[1] = 1'b1;
    tick(HOLD);
    check("R5 still low at hold end", 4'b0010, 4'b0000);
    tick(1);
    check("R5 release after hold", 4'hF, 4'hF);
  endtask

  task automatic testHysteresis();
    aboveHi[2] = 1'b0; belowLo[2] = 1'b0;
    tick(10);
    check("R4 stays high between thresholds", 4'b0100, 4'b0100);
    chanEn[2] = 1'b0;
    tick(1);
    check("R6 enable drop", 4'hF, 4'b1011);
    chanEn[2] = 1'b1;
    tick(HOLD + 5);
    check("R4 stays low between thresholds", 4'b0100, 4'b0000);
    aboveHi[2] = 1'b1;
    tick(2);
    check("R3 rise not yet through sync", 4'b0100, 4'b0000);
    tick(1);
    check("R3 rise on third edge", 4'hF, 4'hF);
  endtask

  task automatic testRun();
    chanRun[3] = 1'b0;
    tick(1);
    check("R7 run drop", 4'hF, 4'b0111);
    chanRun[3] = 1'b1;
    tick(HOLD);
    check("R7 held after run return", 4'b1000, 4'b0000);
    tick(1);
    check("R7 release", 4'hF, 4'hF);
  endtask

  task automatic testFaultShort();
    faultWarn = 1'b1;
    tick(1);
    check("R8 fault drops all", 4'hF, 4'h0);
    tick(4);
    faultWarn = 1'b0;
    tick(HOLD - 4);
    check("R8 short fault full hold", 4'hF, 4'h0);
    tick(1);
    check("R8 short fault release", 4'hF, 4'hF);
  endtask

  task automatic testFaultLong();
    faultWarn = 1'b1;
    tick(1);
    check("R8 long fault drops all", 4'hF, 4'h0);
    tick(HOLD + 10);
    check("R8 low during long fault", 4'hF, 4'h0);
    faultWarn = 1'b0;
    tick(1);
    check("R8 release right after long fault", 4'hF, 4'hF);
  endtask

  task automatic testNoExtend();
    chanEn[0] = 1'b0;
    tick(1);
    check("R9 first drop", 4'b0001, 4'b0000);
    chanEn[0] = 1'b1;
    tick(9);
    chanEn[0] = 1'b0;
    tick(1);
    chanEn[0] = 1'b1;
    tick(HOLD - 10);
    check("R9 low at hold end", 4'b0001, 4'b0000);
    tick(1);
    check("R9 second cause ignored while low", 4'hF, 4'hF);
    chanEn[1] = 1'b0;
    tick(1);
    chanEn[1] = 1'b1;
    tick(HOLD);
    check("R9 redrop full hold", 4'b0010, 4'b0000);
    tick(1);
    check("R9 redrop release", 4'hF, 4'hF);
  endtask

  task automatic testCoincide();
    chanEn[0] = 1'b0;
    tick(1);
    chanEn[0] = 1'b1;
    tick(HOLD);
    check("R5 ch0 low at expiry", 4'b0001, 4'b0000);
    faultWarn = 1'b1;
    tick(1);
    check("R8 fault on expiry edge", 4'hF, 4'h0);
    faultWarn = 1'b0;
    tick(1);
    check("R9 expired ch0 released, others held", 4'hF, 4'b0001);
    tick(HOLD - 1);
    check("R9 others still held", 4'hF, 4'b0001);
    tick(1);
    check("R9 others released", 4'hF, 4'hF);
  endtask

  initial begin
    testReset();
    testBelowDrop();
    testHysteresis();
    testRun();
    testFaultShort();
    testFaultLong();
    testNoExtend();
    testCoincide();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule